// File: doc/BRIEF.md
# DAC Waveform Sequencer

This block is the digital front end of a 12-bit digital-to-analog converter. Software programs it through a small register interface: a buffered data word, a step size, a lower and an upper limit, and a control word. The block drives a 12-bit code to the converter. An external sync strobe decides when that code changes. The strobe is sampled on the block clock, and a rising edge is recognised when the strobe is high at a clock edge after it was low at the clock edge before.

In normal mode the block passes the written word to the output in one of two ways. In immediate mode the word goes out as soon as it is written. In synchronous mode the buffered word goes out on each sync rising edge, and the same word goes out again if software has not written a new one. In automatic mode the buffered word is the starting value. On each sync rising edge the block adds the step to that value or subtracts it, which produces sawtooth, triangle and square waves between the two limits.

When the value reaches a limit, the block turns round according to the two direction enables. It either reverses direction or reloads the opposite limit. The starting direction follows whichever enable was switched on most recently.

Top module: `wave_dac_seq`

## Requirements
- R1: Register offsets are 0 for the buffered word, 1 for the step, 2 for the lower limit, 3 for the upper limit and 4 for control. The four value registers hold their 12-bit value in bus bits 15:4. In those registers, bus bits 3:0 read as zero and ignore writes. Control uses bit 0 for automatic mode, bit 1 for the up enable, bit 2 for the down enable and bit 3 for synchronous mode. All other control bits read as zero.
- R2: After reset every register reads zero and the output code is zero. After reset the block is in normal immediate mode.
- R3: In normal mode with synchronous mode off, a write to the buffered word appears on the output code on the clock edge that takes the write.
- R4: In normal mode with synchronous mode on, the output changes only on a sync rising edge, and it then takes the buffered word. A held-high strobe counts as one edge. An edge that comes with no new write presents the old word again. A write on the same cycle as an edge is presented at the next edge.
- R5: In normal mode the upper limit has no effect on the output, so a word above the upper limit is output unchanged.
- R6: In automatic mode each sync rising edge adds the step to the working value while counting up. An up-step that would pass the upper limit stops at the upper limit.
- R7: While counting up with the down enable off, an edge taken at or above the upper limit reloads the lower limit, which gives a rising sawtooth.
- R8: With both enables on, counting up reverses into counting down at the upper limit, and counting down reverses into counting up at the lower limit, which gives a triangle.
- R9: While counting down with the up enable off, an edge taken at or below the lower limit reloads the upper limit, which gives a falling sawtooth.
- R10: The start direction follows the enable bit that a control write changed from 0 to 1. If one write sets both bits from 0, the start direction is up.
- R11: In automatic mode the output code is limited to the upper limit, while the buffered word keeps its unlimited value.
- R12: With both enables on and a step of at least the upper limit minus the lower limit, successive edges alternate the output between the two limits, which gives a square wave.
- R13: A down-step that would pass below the lower limit, including one that would wrap below zero, stops at the lower limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | 3 | Register offset |
| busWrData | input | 16 | Register write data |
| busRdData | output | 16 | Register read data, combinational from busAddr |
| syncIn | input | 1 | Update strobe, sampled on clk |
| dacCode | output | 12 | Code driven to the converter |

## Verification
On every cycle the assertions check the following:
- An immediate-mode write reaches the output on the edge that takes it.
- A synchronous-mode edge loads the buffered word.
- In synchronous and automatic modes the output never moves without a sync edge.
- Reserved bits read as zero.
- An automatic step never leaves the output above the upper limit.

Only the directed scenarios show the shapes of the waveforms:
- sawtooth reload in both directions
- triangle reversal
- square alternation
- saturation at each limit
- the choice of start direction from the last enable written

// File: rtl/wave_dac_pkg.sv
package wave_dac_pkg;

  typedef enum logic [2:0] {
    REG_DATA = 3'd0,
    REG_STEP = 3'd1,
    REG_MIN  = 3'd2,
    REG_MAX  = 3'd3,
    REG_CTRL = 3'd4
  } regSel_e;

  localparam int CTRL_AUTO = 0;
  localparam int CTRL_UP   = 1;
  localparam int CTRL_DOWN = 2;
  localparam int CTRL_SYNC = 3;
  localparam int CTRL_W    = 4;

  typedef struct packed {
    logic bufWrite;   // buffered word written this cycle
    logic asyncLoad;  // immediate-mode output load
    logic syncLoad;   // synchronous-mode output load on edge
    logic autoStep;   // automatic-mode step on edge
    logic forceUp;    // control write turned up enable on
    logic forceDown;  // control write turned down enable on (alone)
  } seqStrobe_t;

endpackage

// File: rtl/wave_dac_ctrl.sv
module wave_dac_ctrl
  import wave_dac_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int BUS_W  = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BUS_W-1:0]  busWrData,
  input  logic              syncIn,
  input  logic [DATA_W-1:0] dataVal,
  output logic [BUS_W-1:0]  busRdData,
  output logic [DATA_W-1:0] wrField,
  output logic [DATA_W-1:0] stepVal,
  output logic [DATA_W-1:0] minVal,
  output logic [DATA_W-1:0] maxVal,
  output logic              autoEn,
  output logic              upEn,
  output logic              downEn,
  output logic              syncEn,
  output logic              syncRise,
  output seqStrobe_t        strb
);

  localparam int PAD_W = BUS_W - DATA_W;
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(REG_DATA);
  localparam logic [ADDR_W-1:0] A_STEP = ADDR_W'(REG_STEP);
  localparam logic [ADDR_W-1:0] A_MIN  = ADDR_W'(REG_MIN);
  localparam logic [ADDR_W-1:0] A_MAX  = ADDR_W'(REG_MAX);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(REG_CTRL);

  logic syncPrev;
  logic wrData, wrStep, wrMin, wrMax, wrCtrl;
  logic upRise, downRise;
  logic [CTRL_W-1:0] ctrlBits;

  assign wrField = busWrData[BUS_W-1 -: DATA_W];
  assign wrData  = busWrEn && (busAddr == A_DATA);
  assign wrStep  = busWrEn && (busAddr == A_STEP);
  assign wrMin   = busWrEn && (busAddr == A_MIN);
  assign wrMax   = busWrEn && (busAddr == A_MAX);
  assign wrCtrl  = busWrEn && (busAddr == A_CTRL);

  // sync edge detection on the block clock
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncPrev <= 1'b0;
    else       syncPrev <= syncIn;
  end
  assign syncRise = syncIn && !syncPrev;

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stepVal <= '0;
      minVal  <= '0;
      maxVal  <= '0;
      autoEn  <= 1'b0;
      upEn    <= 1'b0;
      downEn  <= 1'b0;
      syncEn  <= 1'b0;
    end else begin
      if (wrStep) stepVal <= wrField;
      if (wrMin)  minVal  <= wrField;
      if (wrMax)  maxVal  <= wrField;
      if (wrCtrl) begin
        autoEn <= busWrData[CTRL_AUTO];
        upEn   <= busWrData[CTRL_UP];
        downEn <= busWrData[CTRL_DOWN];
        syncEn <= busWrData[CTRL_SYNC];
      end
    end
  end

  assign upRise   = busWrData[CTRL_UP]   && !upEn;
  assign downRise = busWrData[CTRL_DOWN] && !downEn;

  always_comb begin
    strb           = '0;
    strb.bufWrite  = wrData;
    strb.asyncLoad = wrData && !autoEn && !syncEn;
    strb.syncLoad  = syncRise && !autoEn && syncEn;
    strb.autoStep  = syncRise && autoEn;
    strb.forceUp   = wrCtrl && upRise;
    strb.forceDown = wrCtrl && downRise && !upRise;
  end

  always_comb begin
    ctrlBits            = '0;
    ctrlBits[CTRL_AUTO] = autoEn;
    ctrlBits[CTRL_UP]   = upEn;
    ctrlBits[CTRL_DOWN] = downEn;
    ctrlBits[CTRL_SYNC] = syncEn;
  end

  always_comb begin
    busRdData = '0;
    unique case (busAddr)
      A_DATA:  busRdData = {dataVal, {PAD_W{1'b0}}};
      A_STEP:  busRdData = {stepVal, {PAD_W{1'b0}}};
      A_MIN:   busRdData = {minVal,  {PAD_W{1'b0}}};
      A_MAX:   busRdData = {maxVal,  {PAD_W{1'b0}}};
      A_CTRL:  busRdData = {{(BUS_W-CTRL_W){1'b0}}, ctrlBits};
      default: busRdData = '0;
    endcase
  end

endmodule

// File: rtl/wave_dac_path.sv
module wave_dac_path
  import wave_dac_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strb,
  input  logic [DATA_W-1:0] wrField,
  input  logic [DATA_W-1:0] stepVal,
  input  logic [DATA_W-1:0] minVal,
  input  logic [DATA_W-1:0] maxVal,
  input  logic              upEn,
  input  logic              downEn,
  output logic [DATA_W-1:0] dataVal,
  output logic [DATA_W-1:0] outCode
);

  localparam int EXT_W = DATA_W + 1;

  logic              dirDownQ;
  logic              effDown;
  logic              nextDown;
  logic              stepTaken;
  logic [EXT_W-1:0]  sumW;
  logic [EXT_W-1:0]  diffW;
  logic [DATA_W-1:0] upVal;
  logic [DATA_W-1:0] dnVal;
  logic [DATA_W-1:0] nextData;
  logic [DATA_W-1:0] limitedOut;

  // one extra bit catches overflow and wrap below zero
  assign sumW  = {1'b0, dataVal} + {1'b0, stepVal};
  assign diffW = {1'b0, dataVal} - {1'b0, stepVal};
  assign upVal = (sumW > {1'b0, maxVal}) ? maxVal : sumW[DATA_W-1:0];
  assign dnVal = (diffW[DATA_W] || (diffW[DATA_W-1:0] < minVal)) ? minVal
                                                                 : diffW[DATA_W-1:0];

  // a disabled direction is never taken
  assign effDown = downEn && (!upEn || dirDownQ);

  always_comb begin
    nextData = dataVal;
    nextDown = dirDownQ;
    if (!upEn && !downEn) begin
      nextData = dataVal;
    end else if (!effDown) begin
      if (dataVal >= maxVal) begin
        if (downEn) begin
          nextData = dnVal;
          nextDown = 1'b1;
        end else begin
          nextData = minVal;
        end
      end else begin
        nextData = upVal;
      end
    end else begin
      if (dataVal <= minVal) begin
        if (upEn) begin
          nextData = upVal;
          nextDown = 1'b0;
        end else begin
          nextData = maxVal;
        end
      end else begin
        nextData = dnVal;
      end
    end
  end

  assign limitedOut = (nextData > maxVal) ? maxVal : nextData;
  assign stepTaken  = strb.autoStep && !strb.bufWrite;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataVal <= '0;
    end else if (strb.bufWrite) begin
      dataVal <= wrField;
    end else if (stepTaken) begin
      dataVal <= nextData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outCode <= '0;
    end else if (strb.asyncLoad) begin
      outCode <= wrField;
    end else if (strb.syncLoad) begin
      outCode <= dataVal;
    end else if (stepTaken) begin
      outCode <= limitedOut;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirDownQ <= 1'b0;
    end else if (strb.forceUp) begin
      dirDownQ <= 1'b0;
    end else if (strb.forceDown) begin
      dirDownQ <= 1'b1;
    end else if (stepTaken) begin
      dirDownQ <= nextDown;
    end
  end

endmodule

// File: rtl/wave_dac_seq.sv
module wave_dac_seq
  import wave_dac_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int BUS_W  = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BUS_W-1:0]  busWrData,
  output logic [BUS_W-1:0]  busRdData,
  input  logic              syncIn,
  output logic [DATA_W-1:0] dacCode
);

  seqStrobe_t        strb;
  logic [DATA_W-1:0] wrField;
  logic [DATA_W-1:0] stepVal;
  logic [DATA_W-1:0] minVal;
  logic [DATA_W-1:0] maxVal;
  logic [DATA_W-1:0] dataVal;
  logic              autoEn;
  logic              upEn;
  logic              downEn;
  logic              syncEn;
  logic              syncRise;

  wave_dac_ctrl #(
    .DATA_W(DATA_W), .BUS_W(BUS_W), .ADDR_W(ADDR_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .busWrEn(busWrEn), .busAddr(busAddr), .busWrData(busWrData),
    .syncIn(syncIn), .dataVal(dataVal), .busRdData(busRdData),
    .wrField(wrField), .stepVal(stepVal), .minVal(minVal), .maxVal(maxVal),
    .autoEn(autoEn), .upEn(upEn), .downEn(downEn), .syncEn(syncEn),
    .syncRise(syncRise), .strb(strb)
  );

  wave_dac_path #(
    .DATA_W(DATA_W)
  ) u_path (
    .clk(clk), .rstN(rstN), .strb(strb), .wrField(wrField),
    .stepVal(stepVal), .minVal(minVal), .maxVal(maxVal),
    .upEn(upEn), .downEn(downEn),
    .dataVal(dataVal), .outCode(dacCode)
  );

endmodule

// File: rtl/wave_dac_seq_chk.sv
module wave_dac_seq_chk #(
  parameter int DATA_W = 12,
  parameter int BUS_W  = 16,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWrEn,
  input logic [ADDR_W-1:0] busAddr,
  input logic [BUS_W-1:0]  busWrData,
  input logic [BUS_W-1:0]  busRdData,
  input logic [DATA_W-1:0] dacCode,
  input logic [DATA_W-1:0] dataVal,
  input logic [DATA_W-1:0] maxVal,
  input logic              autoEn,
  input logic              syncEn,
  input logic              syncRise
);

  localparam int PAD_W = BUS_W - DATA_W;

  AST_RESV_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr < ADDR_W'(4)) |-> (busRdData[PAD_W-1:0] == '0)); // R1

  AST_ASYNC_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == '0 && !autoEn && !syncEn)
      |=> (dacCode == $past(busWrData[BUS_W-1 -: DATA_W]))); // R3

  AST_SYNC_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (syncRise && syncEn && !autoEn) |=> (dacCode == $past(dataVal))); // R4

  AST_HOLD_NO_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    ((syncEn || autoEn) && !syncRise) |=> $stable(dacCode)); // R4

  AST_AUTO_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    (syncRise && autoEn && !(busWrEn && busAddr == '0))
      |=> (dacCode <= $past(maxVal))); // R11

endmodule

bind wave_dac_seq wave_dac_seq_chk #(
  .DATA_W(DATA_W), .BUS_W(BUS_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
  .busWrData(busWrData), .busRdData(busRdData), .dacCode(dacCode),
  .dataVal(dataVal), .maxVal(maxVal), .autoEn(autoEn), .syncEn(syncEn),
  .syncRise(syncRise)
);

// File: tb/wave_dac_seq_tb.sv
`timescale 1ns/1ps
module wave_dac_seq_tb;

  localparam int A_DATA = 0, A_STEP = 1, A_MIN = 2, A_MAX = 3, A_CTRL = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic [2:0]  busAddr = '0;
  logic [15:0] busWrData = '0;
  logic [15:0] busRdData;
  logic        syncIn = 1'b0;
  logic [11:0] dacCode;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  wave_dac_seq u_dut (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .syncIn(syncIn),
    .dacCode(dacCode)
  );

  task automatic checkEq(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    busWrEn = 1'b0;
    syncIn = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic busWrite(input int addr, input logic [15:0] val);
    busAddr = addr[2:0];
    busWrData = val;
    busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic setVal(input int addr, input int v);
    busWrite(addr, {v[11:0], 4'h0});
  endtask

  task automatic readReg(input int addr, output int v);
    busAddr = addr[2:0];
    #1;
    v = busRdData;
  endtask

  task automatic pulseSync();
    syncIn = 1'b1;
    @(negedge clk);
    syncIn = 1'b0;
    @(negedge clk);
  endtask

  task automatic edgeExpect(input string req, input int exp);
    pulseSync();
    checkEq(req, dacCode, exp);
  endtask

  task automatic testReset();
    int v;
    doReset();
    checkEq("R2 output", dacCode, 0);
    for (int a = 0; a < 5; a++) begin
      readReg(a, v);
      checkEq("R2 register", v, 0);
    end
  endtask

  task automatic testRegs();
    int v;
    doReset();
    busWrite(A_STEP, 16'h123F);
    readReg(A_STEP, v);
    checkEq("R1 step justify", v, 16'h1230);
    busWrite(A_MAX, 16'hABCF);
    readReg(A_MAX, v);
    checkEq("R1 max justify", v, 16'hABC0);
    busWrite(A_MIN, 16'h0057);
    readReg(A_MIN, v);
    checkEq("R1 min justify", v, 16'h0050);
    busWrite(A_CTRL, 16'hFFF0);
    readReg(A_CTRL, v);
    checkEq("R1 ctrl reserved", v, 0);
    busWrite(A_CTRL, 16'h000F);
    readReg(A_CTRL, v);
    checkEq("R1 ctrl bits", v, 16'h000F);
  endtask

  task automatic testAsync();
    doReset();
    setVal(A_DATA, 12'h5A0);
    checkEq("R3 immediate load", dacCode, 12'h5A0);
    setVal(A_MAX, 12'h100);
    setVal(A_DATA, 12'h800);
    checkEq("R5 max ignored", dacCode, 12'h800);
  endtask

  task automatic testSync();
    doReset();
    setVal(A_DATA, 12'h111);
    busWrite(A_CTRL, 16'h0008);
    setVal(A_DATA, 12'h300);
    checkEq("R4 no edge hold", dacCode, 12'h111);
    edgeExpect("R4 edge load", 12'h300);
    setVal(A_DATA, 12'h400);
    checkEq("R4 write waits", dacCode, 12'h300);
    edgeExpect("R4 second edge", 12'h400);
    edgeExpect("R4 reuse old word", 12'h400);
    setVal(A_DATA, 12'h500);
    syncIn = 1'b1;
    @(negedge clk);
    checkEq("R4 held high edge", dacCode, 12'h500);
    setVal(A_DATA, 12'h600);
    @(negedge clk);
    checkEq("R4 held high no second", dacCode, 12'h500);
    syncIn = 1'b0;
    @(negedge clk);
    // write on the same cycle as an edge is presented next edge
    busAddr = 3'(A_DATA);
    busWrData = {12'h700, 4'h0};
    busWrEn = 1'b1;
    syncIn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
    syncIn = 1'b0;
    checkEq("R4 collide old word", dacCode, 12'h600);
    @(negedge clk);
    edgeExpect("R4 collide next edge", 12'h700);
  endtask

  task automatic testSawUp();
    doReset();
    setVal(A_MIN, 0);
    setVal(A_MAX, 10);
    setVal(A_STEP, 4);
    setVal(A_DATA, 0);
    busWrite(A_CTRL, 16'h0003);
    edgeExpect("R6 step 1", 4);
    edgeExpect("R6 step 2", 8);
    edgeExpect("R6 saturate at max", 10);
    edgeExpect("R7 reload min", 0);
    edgeExpect("R7 restart", 4);
  endtask

  task automatic testTriangle();
    doReset();
    setVal(A_MIN, 2);
    setVal(A_MAX, 10);
    setVal(A_STEP, 4);
    setVal(A_DATA, 2);
    busWrite(A_CTRL, 16'h0007);
    edgeExpect("R10 both set start up", 6);
    edgeExpect("R8 rise", 10);
    edgeExpect("R8 turn down", 6);
    edgeExpect("R8 fall", 2);
    edgeExpect("R8 turn up", 6);
  endtask

  task automatic testSawDown();
    doReset();
    setVal(A_MIN, 0);
    setVal(A_MAX, 10);
    setVal(A_STEP, 4);
    setVal(A_DATA, 10);
    busWrite(A_CTRL, 16'h0005);
    edgeExpect("R9 down 1", 6);
    edgeExpect("R9 down 2", 2);
    edgeExpect("R13 saturate at min", 0);
    edgeExpect("R9 reload max", 10);
  endtask

  task automatic testDirection();
    doReset();
    setVal(A_MIN, 0);
    setVal(A_MAX, 20);
    setVal(A_STEP, 2);
    setVal(A_DATA, 6);
    busWrite(A_CTRL, 16'h0003);
    busWrite(A_CTRL, 16'h0007);
    edgeExpect("R10 down written last", 4);
    doReset();
    setVal(A_MIN, 0);
    setVal(A_MAX, 20);
    setVal(A_STEP, 2);
    setVal(A_DATA, 6);
    busWrite(A_CTRL, 16'h0005);
    busWrite(A_CTRL, 16'h0007);
    edgeExpect("R10 up written last", 8);
  endtask

  task automatic testSquare();
    doReset();
    setVal(A_MIN, 3);
    setVal(A_MAX, 12);
    setVal(A_STEP, 9);
    setVal(A_DATA, 3);
    busWrite(A_CTRL, 16'h0007);
    edgeExpect("R12 high", 12);
    edgeExpect("R12 low", 3);
    edgeExpect("R12 high again", 12);
    edgeExpect("R12 low again", 3);
  endtask

  task automatic testClamp();
    int v;
    doReset();
    setVal(A_MIN, 0);
    setVal(A_MAX, 10);
    setVal(A_STEP, 2);
    setVal(A_DATA, 15);
    busWrite(A_CTRL, 16'h0005);
    edgeExpect("R11 output limited", 10);
    readReg(A_DATA, v);
    checkEq("R11 word unlimited", v, 13 << 4);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    testReset();
    testRegs();
    testAsync();
    testSync();
    testSawUp();
    testTriangle();
    testSawDown();
    testDirection();
    testSquare();
    testClamp();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule